// File: doc/BRIEF.md
# Glitch-free clock group stop gate

This block produces a group of clock outputs from one internally divided reference phase. An active-low stop request parks every output whose per-lane stoppable bit is set. Lanes whose bit is clear keep running. The outputs only ever change on the reference's half-period boundaries, so stopping and restarting never produces a shortened or stretched pulse.

One parameter selects between two variants of the same logic:

- **Processor group.** A stopped lane holds its true output high and its complement low. The gate acts on the rising boundary that follows the second falling-edge sample of the request.
- **Peripheral group.** A stopped lane holds its output low. The stop pin is combined with a register stop bit, and the gate acts on the falling boundary at which the request has been seen on two falling edges.

A readback output reports whether the stoppable clocks are allowed to run.

The reference clock is a register toggling every `HALF_CYC` cycles of `clk`, starting low after reset. A lane that is running shows exactly this waveform.

Top module: `clk_stop_gate`

## Requirements
- R1: After a stop request is asserted, every lane keeps following the reference waveform for at least one full reference period. A lane parks no earlier than the second falling edge of the reference that samples the request.
- R2: While stopped, a stoppable lane holds its park level steadily. The park level is true high and complement low for the processor group, and output low for the peripheral group. In the processor group the complement output is always the inverse of the true output.
- R3: Within three reference periods of the request being released, every stopped lane again equals the reference waveform.
- R4: A lane whose stoppable bit is 0 equals the reference waveform at all times, whatever the stop inputs do.
- R5: No output high or low time is shorter than `HALF_CYC` clock cycles, and outputs change only on reference half-period boundaries.
- R6: In the peripheral group, the effective request is `stop_pin_n & stop_reg`. A low on either input stops the stoppable lanes.
- R7: `stop_rb` reads `stop_pin_n & stop_reg` in the peripheral group and `stop_pin_n` in the processor group. A 0 means the stoppable clocks are halted or halting.
- R8: In the processor group, `stop_reg` has no effect on the outputs.
- R9: During and right after reset, the true outputs are low (complement high in the processor group). The reference waveform is low for `HALF_CYC` cycles and high for `HALF_CYC` cycles, repeating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that the reference is divided from |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_pin_n | input | 1 | Active-low stop request pin |
| stop_reg | input | 1 | Register stop bit, active low (peripheral group only) |
| stoppable | input | N_OUT | Per-lane stoppable enable, 1 = lane stops on request |
| clk_t | output | N_OUT | True clock outputs |
| clk_c | output | N_OUT | Complement outputs (processor group); 0 in peripheral group |
| stop_rb | output | 1 | Readback of the combined stop request, 1 = clocks allowed to run |

## Verification
The reference waveform after k clock edges since reset release is (k / HALF_CYC) mod 2. Outputs are registered on the same edge as the reference, so each running lane is compared against that value at the falling edge of `clk`.

Stop requests are driven on a falling edge. Lanes are required to track the reference for one full period (2·HALF_CYC cycles) afterwards, and the park level is checked only after three periods, which covers two falling samples plus the processor group's wait for a rising boundary. Release is checked three periods after the request is removed. The readback is checked one cycle after its inputs change, because it is combinational. Free lanes, complement inversion and minimum pulse widths are monitored on every cycle and reported at the end.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic {
        GRP_CPU = 1'b0,
        GRP_PCI = 1'b1
    } grp_e;
endpackage

// File: rtl/clkstop_phase.sv
// Divides clk into the reference phase and flags its half-period boundaries.
module clkstop_phase #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_q,
    output logic phase_nxt,
    output logic tog,
    output logic fall_t,
    output logic rise_t
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_q   = st_q.ph;
    assign phase_nxt = st_d.ph;
    assign tog       = (st_q.cnt == LAST);
    assign fall_t    = tog & st_q.ph;
    assign rise_t    = tog & ~st_q.ph;
endmodule

// File: rtl/clkstop_sampler.sv
// Two-stage sampler of the stop request, clocked on reference falling boundaries.
module clkstop_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_t,
    input  logic req_n,
    output logic stop_first,
    output logic stop_q
);
    typedef struct packed {
        logic s1;
        logic s2;
    } smp_st_t;

    smp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_t) begin
            st_d.s1 = req_n;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1};
        else        st_q <= st_d;
    end

    assign stop_first = ~st_q.s1;
    assign stop_q     = ~st_q.s2;
endmodule

// File: rtl/clkstop_lane.sv
// One gated output. The run flag moves only on the boundary where the
// reference is already at the park level.
module clkstop_lane #(
    parameter bit PARK_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic park_t,
    input  logic phase_nxt,
    input  logic stoppable,
    input  logic stop_eff,
    output logic out_q,
    output logic run_q
);
    typedef struct packed {
        logic run;
        logic out;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (park_t) st_d.run = ~(stoppable & stop_eff);
        st_d.out = st_d.run ? phase_nxt : PARK_HIGH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{run: 1'b1, out: 1'b0};
        else        st_q <= st_d;
    end

    assign out_q = st_q.out;
    assign run_q = st_q.run;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter clkstop_pkg::grp_e GROUP    = clkstop_pkg::GRP_CPU,
    parameter int                N_OUT    = 2,
    parameter int                HALF_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_pin_n,
    input  logic             stop_reg,
    input  logic [N_OUT-1:0] stoppable,
    output logic [N_OUT-1:0] clk_t,
    output logic [N_OUT-1:0] clk_c,
    output logic             stop_rb
);
    localparam bit IS_PCI = (GROUP == clkstop_pkg::GRP_PCI);

    logic phase_q, phase_nxt, tog, fall_t, rise_t;
    logic req_n, stop_first, stop_q, stop_eff, park_t;
    logic [N_OUT-1:0] run_vec;

    clkstop_phase #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_nxt(phase_nxt),
        .tog(tog), .fall_t(fall_t), .rise_t(rise_t)
    );

    assign req_n   = IS_PCI ? (stop_pin_n & stop_reg) : stop_pin_n;
    assign stop_rb = req_n;

    clkstop_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .fall_t(fall_t), .req_n(req_n),
        .stop_first(stop_first), .stop_q(stop_q)
    );

    // Peripheral group parks low on a falling boundary, acting on the sample
    // taken one fall earlier; processor group parks high on the rising boundary
    // after the second falling sample.
    assign park_t   = IS_PCI ? fall_t : rise_t;
    assign stop_eff = IS_PCI ? stop_first : stop_q;

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        clkstop_lane #(.PARK_HIGH(!IS_PCI)) u_lane (
            .clk(clk), .rst_n(rst_n), .park_t(park_t), .phase_nxt(phase_nxt),
            .stoppable(stoppable[i]), .stop_eff(stop_eff),
            .out_q(clk_t[i]), .run_q(run_vec[i])
        );
        if (IS_PCI) begin : g_pci
            assign clk_c[i] = 1'b0;
        end else begin : g_cpu
            assign clk_c[i] = ~clk_t[i];
        end
    end
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
    parameter int N_OUT    = 2,
    parameter int HALF_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tog,
    input logic             fall_t,
    input logic             park_t,
    input logic             stop_q,
    input logic             stop_eff,
    input logic [N_OUT-1:0] stoppable,
    input logic [N_OUT-1:0] run_vec,
    input logic [N_OUT-1:0] clk_t
);
    localparam int LW = $clog2(HALF_CYC + 1) + 1;

    // R1: the second-stage stop sample only moves on a reference falling boundary
    p_sample_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stop_q) |-> $past(fall_t));

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        logic [LW-1:0] len_q;
        logic          last_q, seen_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q <= '0; last_q <= 1'b0; seen_q <= 1'b0;
            end else if (clk_t[i] != last_q) begin
                len_q <= LW'(1); last_q <= clk_t[i]; seen_q <= 1'b1;
            end else if (len_q < LW'(HALF_CYC)) begin
                len_q <= len_q + 1'b1;
            end
        end

        // R5: outputs only change on half-period boundaries
        p_edge_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(clk_t[i]) |-> $past(tog));

        // R5: no level shorter than a half period
        p_min_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && clk_t[i] != last_q) |-> (len_q >= LW'(HALF_CYC)));

        // R2: the run flag only moves on the park boundary
        p_park_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(run_vec[i]) |-> $past(park_t));

        // R4: a lane only stops when it was stoppable and a stop was in effect
        p_free_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_vec[i]) |-> $past(stoppable[i] && stop_eff));
    end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_OUT(N_OUT), .HALF_CYC(HALF_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .tog(tog), .fall_t(fall_t), .park_t(park_t),
    .stop_q(stop_q), .stop_eff(stop_eff), .stoppable(stoppable),
    .run_vec(run_vec), .clk_t(clk_t)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
    localparam int N = 2;
    localparam int H = 2;
    localparam int P = 2 * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c_pin = 1'b1, c_reg = 1'b1, p_pin = 1'b1, p_reg = 1'b1;
    logic [N-1:0] c_mask = '0, p_mask = '0;
    logic [N-1:0] c_t, c_c, p_t, p_c;
    logic c_rb, p_rb;

    int checks = 0, errors = 0;
    int free_err = 0, comp_err = 0, wid_err = 0;
    int k = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clk_stop_gate #(.GROUP(clkstop_pkg::GRP_CPU), .N_OUT(N), .HALF_CYC(H)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_pin_n(c_pin), .stop_reg(c_reg),
        .stoppable(c_mask), .clk_t(c_t), .clk_c(c_c), .stop_rb(c_rb)
    );
    clk_stop_gate #(.GROUP(clkstop_pkg::GRP_PCI), .N_OUT(N), .HALF_CYC(H)) u1 (
        .clk(clk), .rst_n(rst_n), .stop_pin_n(p_pin), .stop_reg(p_reg),
        .stoppable(p_mask), .clk_t(p_t), .clk_c(p_c), .stop_rb(p_rb)
    );

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    function automatic int ref_wave();
        return (k / H) % 2;
    endfunction

    function automatic int lane(input int inst, input int i);
        return (inst == 0) ? int'(c_t[i]) : int'(p_t[i]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // continuous monitors: free lanes (R4), complement (R2), widths (R5)
    int last_v [4];
    int run_len [4];
    bit seen_v [4];
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (!c_mask[i] && int'(c_t[i]) != ref_wave()) free_err++;
                if (!p_mask[i] && int'(p_t[i]) != ref_wave()) free_err++;
                if (c_c[i] != ~c_t[i]) comp_err++;
                if (p_c[i] != 1'b0) comp_err++;
            end
            for (int s = 0; s < 4; s++) begin
                int v;
                v = (s < 2) ? int'(c_t[s]) : int'(p_t[s-2]);
                if (v != last_v[s]) begin
                    if (seen_v[s] && run_len[s] < H) wid_err++;
                    seen_v[s] = 1;
                    last_v[s] = v;
                    run_len[s] = 1;
                end else begin
                    run_len[s]++;
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_case(input int inst, input int mask, input int via_reg);
        int trk_bad, hold_bad, park;
        park = (inst == 0) ? 1 : 0;
        if (inst == 0) c_mask = N'(mask); else p_mask = N'(mask);
        wait_n(2 * P);
        if (inst == 0) c_pin = 1'b0;
        else if (via_reg != 0) p_reg = 1'b0;
        else p_pin = 1'b0;
        trk_bad = 0;
        for (int n = 0; n < P; n++) begin
            @(negedge clk);
            if (n == 0) begin
                chk("R7 readback low on request", (inst == 0) ? int'(c_rb) : int'(p_rb), 0);
                if (inst == 1) chk("R6 either input low gives low request", int'(p_rb), 0);
            end
            for (int i = 0; i < N; i++)
                if (lane(inst, i) != ref_wave()) trk_bad++;
        end
        chk("R1 lanes track for a period after request", trk_bad, 0);
        wait_n(2 * P);
        for (int i = 0; i < N; i++)
            if (mask[i]) chk("R2 park level", lane(inst, i), park);
            else         chk("R4 free lane runs while stopped", lane(inst, i), ref_wave());
        hold_bad = 0;
        for (int n = 0; n < P; n++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++)
                if (mask[i] && lane(inst, i) != park) hold_bad++;
        end
        chk("R2 park level held", hold_bad, 0);
        if (inst == 0) c_pin = 1'b1;
        else begin p_pin = 1'b1; p_reg = 1'b1; end
        @(negedge clk);
        chk("R7 readback high on release", (inst == 0) ? int'(c_rb) : int'(p_rb), 1);
        wait_n(3 * P - 1);
        for (int i = 0; i < N; i++)
            chk("R3 lane resumes in phase", lane(inst, i), ref_wave());
        wait_n(H + 1);
        for (int i = 0; i < N; i++)
            chk("R3 lane running after resume", lane(inst, i), ref_wave());
    endtask

    initial begin
        int bad;
        @(negedge clk);
        chk("R9 reset true low cpu", int'(c_t), 0);
        chk("R9 reset complement high cpu", int'(c_c), 3);
        chk("R9 reset true low pci", int'(p_t), 0);
        @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int n = 0; n < 4 * P; n++) begin
            @(negedge clk);
            if (int'(c_t[0]) != (k / H) % 2 || int'(p_t[0]) != (k / H) % 2) bad++;
        end
        chk("R9 reference waveform after reset", bad, 0);
        chk("R7 readback idle cpu", int'(c_rb), 1);
        chk("R7 readback idle pci", int'(p_rb), 1);

        for (int m = 0; m < (1 << N); m++) begin
            stop_case(0, m, 0);
            stop_case(1, m, 0);
            stop_case(1, m, 1);
        end

        // R6: both pin and register low together
        p_mask = '1;
        wait_n(P);
        p_pin = 1'b0; p_reg = 1'b0;
        wait_n(3 * P);
        chk("R6 both low parks lane0", int'(p_t[0]), 0);
        chk("R6 both low readback", int'(p_rb), 0);
        p_pin = 1'b1;
        wait_n(3 * P);
        chk("R6 register alone keeps lanes stopped", int'(p_t[1]), 0);
        p_reg = 1'b1;
        wait_n(3 * P);
        chk("R6 lanes resume after both released", int'(p_t[1]), ref_wave());

        // R8: register bit ignored by the processor group
        c_mask = '1;
        c_reg = 1'b0;
        bad = 0;
        for (int n = 0; n < 4 * P; n++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (int'(c_t[i]) != ref_wave()) bad++;
        end
        chk("R8 cpu lanes ignore register bit", bad, 0);
        chk("R8 cpu readback ignores register bit", int'(c_rb), 1);
        c_reg = 1'b1;

        chk("R4 free lanes always match reference", free_err, 0);
        chk("R2 complement inverse of true", comp_err, 0);
        chk("R5 no short high or low time", wid_err, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule